// File: doc/BRIEF.md
# Edge-Detecting Interrupt Flag Controller

This block gathers interrupt causes into one 8-bit flag register beside an 8-bit enable (mask) register. It raises a single registered interrupt request toward the CPU core. The causes come from three kinds of source:

- Overflow pulses from three timers.
- Eight external port pins, in three groups.
- A completion level from the serial engine.

The port pins are asynchronous. Each pin passes through a two-flop synchroniser before its edges are detected.

The pins form three groups. Pins 0 to 3 share one flag and pins 4 to 6 share a second; both sets on falling edges. Pin 7 has its own flag, and a mode input chooses whether it sets on the falling edge only or on both edges. The serial source is a level that goes high when a transfer finishes, and only its rising edge sets a flag.

Software reads both registers directly on the output ports. Writing the flag register clears every bit written as 0. Writing the mask register loads it.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `flag_o`, `mask_o` and `irq_o` are all zero.
- R2: A high level on `tmr_ovf_i`, `cnt1_ovf_i` or `cnt2_ovf_i` at a rising clock edge sets flag bit 0, 1 or 2 respectively at that edge.
- R3: A falling edge on any of `pin_i[3:0]` sets flag bit 3 at the third rising clock edge after the pin changes, not earlier; a rising edge on these pins sets nothing.
- R4: A falling edge on any of `pin_i[6:4]` sets flag bit 4 with the same three-edge latency as R3; a rising edge on these pins sets nothing.
- R5: A falling edge on `pin_i[7]` sets flag bit 5 with the R3 latency. A rising edge on `pin_i[7]` also sets flag bit 5 when `dual_edge_i` is 1, and sets nothing when it is 0.
- R6: A rising edge of `srx_full_i` sets flag bit 7 at the next clock edge. A falling edge does not set it, and a level that stays high does not set it again once it has been cleared.
- R7: Flag bit 6 always reads 0.
- R8: A cycle with `flag_wr_i` high clears every flag bit whose `flag_wdata_i` bit is 0 and leaves every bit written as 1 unchanged.
- R9: If a set event and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R10: A cycle with `mask_wr_i` high loads `mask_wdata_i` into the mask register, and the new value is visible on `mask_o` after that edge.
- R11: `irq_o` equals the OR over all bits of (flag AND mask) from the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_i | input | 1 | Main timer overflow pulse |
| cnt1_ovf_i | input | 1 | Counter 1 overflow pulse |
| cnt2_ovf_i | input | 1 | Counter 2 overflow pulse |
| pin_i | input | 8 | Asynchronous external port pin levels |
| srx_full_i | input | 1 | Serial receive-complete level |
| dual_edge_i | input | 1 | 1: pin 7 flags on both edges; 0: falling edge only |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Flag write data (0 bits clear) |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| flag_o | output | 8 | Flag register contents |
| mask_o | output | 8 | Mask register contents |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, a two-stage synchroniser, and the 4/3/1 pin grouping. At this size every configuration is small enough to sweep in full.

- Every pin is driven through a falling and a rising edge under both edge modes. The flag is checked one edge before and exactly at its expected set time.
- All 256 mask values are applied to a fully set flag register.
- All 256 clear patterns are applied to a fully set flag register.

Together these reach the grouping, the edge selection, the latency and the clear and masking rules for every bit.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int FLAG_W    = 8;
  localparam int B_TMR     = 0;
  localparam int B_CNT1    = 1;
  localparam int B_CNT2    = 2;
  localparam int B_GRP_A   = 3;
  localparam int B_GRP_B   = 4;
  localparam int B_DUAL    = 5;
  localparam int B_SPARE   = 6;
  localparam int B_SERIAL  = 7;
  // Bits that can ever hold a 1.
  localparam logic [FLAG_W-1:0] IMPL_MASK = ~(FLAG_W'(1) << B_SPARE);
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int   W       = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= {W{RST_VAL}};
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqf_edge.sv
module irqf_edge #(
  parameter int   W       = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= {W{RST_VAL}};
    else        prev_q <= lvl_i;
  end

  always_comb begin
    fall_o = prev_q & ~lvl_i;
    rise_o = ~prev_q & lvl_i;
  end
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              flag_wr_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  input  logic              mask_wr_i,
  input  logic [FLAG_W-1:0] mask_wdata_i,
  output logic [FLAG_W-1:0] flag_o,
  output logic [FLAG_W-1:0] mask_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flag_q, flag_d, mask_q, keep;
  logic              flag_en, irq_q, irq_d;

  // Next-state logic.
  always_comb begin
    keep    = flag_wr_i ? flag_wdata_i : {FLAG_W{1'b1}};
    flag_d  = ((flag_q & keep) | set_i) & IMPL_MASK;
    flag_en = flag_wr_i | (|set_i);
    irq_d   = |(flag_q & mask_q);
  end

  // Register processes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  p_spare_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o[B_SPARE] == 1'b0);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & IMPL_MASK)) |=> ((flag_o & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_i |=> ((flag_o & ~$past(flag_wdata_i | set_i)) == '0));

  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> (mask_o == $past(mask_wdata_i)));

  p_irq_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_o & mask_o)) |=> irq_o);

  p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_o & mask_o)) |=> !irq_o);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqf_pkg::*;
#(
  parameter int              PIN_W       = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [PIN_W-1:0] GRP_A_PINS = 8'h0F,
  parameter logic [PIN_W-1:0] GRP_B_PINS = 8'h70,
  parameter int              DUAL_PIN    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              cnt1_ovf_i,
  input  logic              cnt2_ovf_i,
  input  logic [PIN_W-1:0]  pin_i,
  input  logic              srx_full_i,
  input  logic              dual_edge_i,
  input  logic              flag_wr_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  input  logic              mask_wr_i,
  input  logic [FLAG_W-1:0] mask_wdata_i,
  output logic [FLAG_W-1:0] flag_o,
  output logic [FLAG_W-1:0] mask_o,
  output logic              irq_o
);
  localparam logic [PIN_W-1:0] DUAL_SEL = PIN_W'(1) << DUAL_PIN;

  logic [PIN_W-1:0]  pin_sync, pin_fall, pin_rise;
  logic [FLAG_W-1:0] set_vec;
  logic              srx_q, srx_rise;
  logic              hit_a, hit_b, hit_dual;

  irqf_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  irqf_edge #(.W(PIN_W), .RST_VAL(1'b1)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pin_sync),
    .fall_o (pin_fall),
    .rise_o (pin_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srx_q <= 1'b0;
    else        srx_q <= srx_full_i;
  end

  always_comb begin
    srx_rise = srx_full_i & ~srx_q;
    hit_a    = |(pin_fall & GRP_A_PINS);
    hit_b    = |(pin_fall & GRP_B_PINS);
    hit_dual = (|(pin_fall & DUAL_SEL)) | (dual_edge_i & (|(pin_rise & DUAL_SEL)));
    set_vec            = '0;
    set_vec[B_TMR]     = tmr_ovf_i;
    set_vec[B_CNT1]    = cnt1_ovf_i;
    set_vec[B_CNT2]    = cnt2_ovf_i;
    set_vec[B_GRP_A]   = hit_a;
    set_vec[B_GRP_B]   = hit_b;
    set_vec[B_DUAL]    = hit_dual;
    set_vec[B_SERIAL]  = srx_rise;
  end

  irqf_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (set_vec),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .flag_o       (flag_o),
    .mask_o       (mask_o),
    .irq_o        (irq_o)
  );

  p_serial_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srx_full_i && !srx_q) |=> flag_o[B_SERIAL]);

  p_timer_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_o[B_TMR]);

  p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_edge_i && !(|(pin_fall & DUAL_SEL)) && !flag_o[B_DUAL] && !mask_wr_i)
      |=> !flag_o[B_DUAL]);
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tmr_ovf_i, cnt1_ovf_i, cnt2_ovf_i;
  logic [7:0] pin_i;
  logic       srx_full_i, dual_edge_i;
  logic       flag_wr_i, mask_wr_i;
  logic [7:0] flag_wdata_i, mask_wdata_i;
  logic [7:0] flag_o, mask_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tmr_ovf_i    (tmr_ovf_i),
    .cnt1_ovf_i   (cnt1_ovf_i),
    .cnt2_ovf_i   (cnt2_ovf_i),
    .pin_i        (pin_i),
    .srx_full_i   (srx_full_i),
    .dual_edge_i  (dual_edge_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .flag_o       (flag_o),
    .mask_o       (mask_o),
    .irq_o        (irq_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    flag_wr_i = 1'b1; flag_wdata_i = 8'h00;
    tick(1);
    flag_wr_i = 1'b0; flag_wdata_i = 8'hFF;
  endtask

  task automatic set_all();
    tmr_ovf_i = 1'b1; cnt1_ovf_i = 1'b1; cnt2_ovf_i = 1'b1;
    tick(1);
    tmr_ovf_i = 1'b0; cnt1_ovf_i = 1'b0; cnt2_ovf_i = 1'b0;
    pin_i = 8'h6E;
    tick(3);
    pin_i = 8'hFF;
    tick(3);
    srx_full_i = 1'b1;
    tick(1);
    srx_full_i = 1'b0;
    tick(1);
  endtask

  function automatic int grp_bit(input int p);
    if (p < 4)      return 3;
    else if (p < 7) return 4;
    else            return 5;
  endfunction

  initial begin
    rst_n = 1'b0;
    tmr_ovf_i = 1'b0; cnt1_ovf_i = 1'b0; cnt2_ovf_i = 1'b0;
    pin_i = 8'hFF; srx_full_i = 1'b0; dual_edge_i = 1'b0;
    flag_wr_i = 1'b0; flag_wdata_i = 8'hFF;
    mask_wr_i = 1'b0; mask_wdata_i = 8'h00;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    check("R1 flag reset", flag_o, 8'h00);
    check("R1 mask reset", mask_o, 8'h00);
    check("R1 irq reset", irq_o, 1'b0);

    // R2: each timer pulse alone
    for (int b = 0; b < 3; b++) begin
      clear_flags();
      tmr_ovf_i = (b == 0); cnt1_ovf_i = (b == 1); cnt2_ovf_i = (b == 2);
      tick(1);
      tmr_ovf_i = 1'b0; cnt1_ovf_i = 1'b0; cnt2_ovf_i = 1'b0;
      check("R2 timer overflow flag", flag_o, 32'(1) << b);
    end

    // R3/R4/R5: every pin, both edges, both modes
    for (int m = 0; m < 2; m++) begin
      dual_edge_i = m[0];
      for (int p = 0; p < 8; p++) begin
        clear_flags();
        pin_i[p] = 1'b0;
        tick(2);
        check(p < 4 ? "R3 fall early" : (p < 7 ? "R4 fall early" : "R5 fall early"), flag_o, 8'h00);
        tick(1);
        check(p < 4 ? "R3 fall set" : (p < 7 ? "R4 fall set" : "R5 fall set"),
              flag_o, 32'(1) << grp_bit(p));
        clear_flags();
        pin_i[p] = 1'b1;
        tick(3);
        check(p < 4 ? "R3 rise ignored" : (p < 7 ? "R4 rise ignored" : "R5 rise dual"),
              flag_o, (p == 7 && m == 1) ? 8'h20 : 8'h00);
      end
    end
    dual_edge_i = 1'b0;

    // R6: serial rising edge, held level, falling edge
    clear_flags();
    srx_full_i = 1'b1;
    tick(1);
    check("R6 serial rise", flag_o, 8'h80);
    clear_flags();
    tick(3);
    check("R6 held level no reset", flag_o, 8'h00);
    srx_full_i = 1'b0;
    tick(2);
    check("R6 fall ignored", flag_o, 8'h00);

    // R7/R8: every clear pattern on a full register
    for (int w = 0; w < 256; w++) begin
      set_all();
      check("R7 all set, bit6 zero", flag_o, 8'hBF);
      flag_wr_i = 1'b1; flag_wdata_i = w[7:0];
      tick(1);
      flag_wr_i = 1'b0; flag_wdata_i = 8'hFF;
      check("R8 clear pattern", flag_o, 8'hBF & w[7:0]);
    end

    // R9: set beats clear in the same cycle
    set_all();
    flag_wr_i = 1'b1; flag_wdata_i = 8'h00; cnt1_ovf_i = 1'b1; srx_full_i = 1'b1;
    tick(1);
    flag_wr_i = 1'b0; flag_wdata_i = 8'hFF; cnt1_ovf_i = 1'b0;
    check("R9 set wins", flag_o, 8'h82);
    srx_full_i = 1'b0;
    tick(1);

    // R10/R11: every mask value on a full register, then on empty
    set_all();
    for (int m = 0; m < 256; m++) begin
      mask_wr_i = 1'b1; mask_wdata_i = m[7:0];
      tick(1);
      mask_wr_i = 1'b0;
      check("R10 mask load", mask_o, m[7:0]);
      tick(1);
      check("R11 irq full flags", irq_o, |(m[7:0] & 8'hBF));
    end
    clear_flags();
    tick(1);
    check("R11 irq no flags", irq_o, 1'b0);
    tmr_ovf_i = 1'b1;
    tick(1);
    tmr_ovf_i = 1'b0;
    check("R11 irq one cycle late", irq_o, 1'b0);
    tick(1);
    check("R11 irq follows flag", irq_o, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule